// File: doc/BRIEF.md
# CPU Clock Ratio Strobe Generator

This block turns one of three source tick streams into four related clock-enable strobes for a CPU clock domain. All four strobes are single-cycle pulses in the system clock domain. A two-bit select code picks the source stream. A programmable divisor then forms a base tick from it. Fixed sub-ratios of that base tick give the four outputs: the fastest strobe, a half-rate strobe, a "two-x" strobe and a "one-x" strobe.

A mode bit picks one of two ratio families. With the mode bit set, the outputs relate as 6:3:2:1. With it clear, they relate as 4:2:2:1. Each output has its own gate bit, so software can silence any strobe on its own. All strobes are phase aligned: at the first base tick of each common period (six base ticks in one family, four in the other), every enabled strobe fires. Divisor and mode changes wait for a period boundary, so the pulse spacing never becomes irregular.

Software reaches two 32-bit registers through a simple register port. The control register holds the source select, the divisor and the four gates. The mode register holds the ratio-family bit.

Top module: `cpu_ratio_gen`

## Requirements
- R1: After reset, the control register reads 0x0000_0100 (divisor 1, select 00, all gates off), the mode register reads 0, and no strobe is asserted.
- R2: Select code 00 or 01 in control bits 5:4 uses the armTick stream, code 10 uses ddrTick and code 11 uses ioTick. Ticks on an unselected stream produce no strobe.
- R3: With regSel=0, the control register is accessed: the select is at bits 5:4, the divisor at bits 13:8 and the gates at bits 27:24. With regSel=1, the mode register is accessed, with the mode in bit 0. All other bits read as 0. A base tick occurs on every D-th tick of the selected stream, where D is the divisor.
- R4: The fastest strobe (rateEn[0]) fires on every base tick. The half-rate strobe (rateEn[1]) fires on every second base tick. On the first base tick of every common period, all enabled strobes fire together.
- R5: With mode bit 0, the common period is 4 base ticks. rateEn[2] fires on base ticks 0 and 2 of the period, and rateEn[3] fires on base tick 0.
- R6: With mode bit 1, the common period is 6 base ticks. rateEn[2] fires on base ticks 0 and 3 of the period, and rateEn[3] fires on base tick 0.
- R7: Control bits 24, 25, 26 and 27 gate rateEn[0], [1], [2] and [3] respectively. A strobe whose gate is 0 never pulses.
- R8: A change of the divisor or the mode bit made inside a common period takes effect only from the start of the next period.
- R9: A divisor of 0 behaves as a divisor of 1, and it reads back as 0.
- R10: A strobe is high for exactly one cycle. It appears in the cycle after the edge that samples the completing source tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control register, 1 selects the mode register |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register |
| armTick | input | 1 | Source tick stream for select codes 00 and 01 |
| ddrTick | input | 1 | Source tick stream for select code 10 |
| ioTick | input | 1 | Source tick stream for select code 11 |
| rateEn | output | 4 | Strobes, from fastest (bit 0) to one-x (bit 3) |

## Verification
The bench builds the block with its default 6-bit divisor field. It drives divisors of 0, 1, 2 and 3, so that full common periods in both ratio families fit in a few dozen cycles. Base ticks are counted with gaps, so every phase of both families is checked. The bench also checks mode and divisor writes made partway through a period, each of the four select codes, and single-gate patterns.

// File: rtl/cpuratio_pkg.sv
package cpuratio_pkg;

  // Register word layout (positions decoded by software)
  localparam int REG_W     = 32;
  localparam int SRC_LSB   = 4;
  localparam int SRC_W     = 2;
  localparam int DIV_LSB   = 8;
  localparam int DIV_W     = 6;
  localparam int GATE_LSB  = 24;
  localparam int N_OUT     = 4;

  // Ratio families
  localparam int PERIOD_WIDE   = 6;   // mode 1: 6:3:2:1
  localparam int PERIOD_NARROW = 4;   // mode 0: 4:2:2:1
  localparam int PH_W          = $clog2(PERIOD_WIDE);

  // Source select codes
  localparam logic [SRC_W-1:0] SEL_DDR = 2'b10;
  localparam logic [SRC_W-1:0] SEL_IO  = 2'b11;

  // Configuration carried from the register bank to the datapath
  typedef struct packed {
    logic [SRC_W-1:0] srcSel;
    logic [DIV_W-1:0] divisor;
    logic             ratioMode;
    logic [N_OUT-1:0] gate;
  } cfgBus_t;

  // Base ticks between pulses of output idx
  function automatic int unsigned ratioOf(int idx, logic mode);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return mode ? 3 : 2;
      default: return mode ? 6 : 4;
    endcase
  endfunction

endpackage

// File: rtl/cpuratio_regs.sv
module cpuratio_regs
  import cpuratio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output cfgBus_t          cfg
);

  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(1);

  logic [SRC_W-1:0] srcSelQ;
  logic [DIV_W-1:0] divQ;
  logic [N_OUT-1:0] gateQ;
  logic             modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSelQ <= '0;
      divQ    <= DIV_RESET;
      gateQ   <= '0;
      modeQ   <= 1'b0;
    end else if (wrEn) begin
      if (regSel) begin
        modeQ <= wrData[0];
      end else begin
        srcSelQ <= wrData[SRC_LSB +: SRC_W];
        divQ    <= wrData[DIV_LSB +: DIV_W];
        gateQ   <= wrData[GATE_LSB +: N_OUT];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (regSel) begin
      rdData[0] = modeQ;
    end else begin
      rdData[SRC_LSB +: SRC_W]  = srcSelQ;
      rdData[DIV_LSB +: DIV_W]  = divQ;
      rdData[GATE_LSB +: N_OUT] = gateQ;
    end
  end

  always_comb begin
    cfg.srcSel    = srcSelQ;
    cfg.divisor   = divQ;
    cfg.ratioMode = modeQ;
    cfg.gate      = gateQ;
  end

endmodule

// File: rtl/cpuratio_core.sv
module cpuratio_core
  import cpuratio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfgBus_t          cfg,
  input  logic             armTick,
  input  logic             ddrTick,
  input  logic             ioTick,
  output logic [N_OUT-1:0] rateEn
);

  localparam logic [PH_W-1:0] LAST_WIDE   = PH_W'(PERIOD_WIDE - 1);
  localparam logic [PH_W-1:0] LAST_NARROW = PH_W'(PERIOD_NARROW - 1);

  logic             srcTick;
  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  phase;
  logic [DIV_W-1:0] shDiv;
  logic             shMode;
  logic             atBoundary;
  logic [DIV_W-1:0] rawDiv;
  logic [DIV_W-1:0] divLast;
  logic             effMode;
  logic [PH_W-1:0]  phaseLast;
  logic             baseHit;
  logic [N_OUT-1:0] phaseHit;

  // Source select
  always_comb begin
    case (cfg.srcSel)
      SEL_DDR: srcTick = ddrTick;
      SEL_IO:  srcTick = ioTick;
      default: srcTick = armTick;
    endcase
  end

  // Settings are sampled only while sitting on a period boundary
  assign atBoundary = (divCnt == '0) && (phase == '0);
  assign rawDiv     = atBoundary ? cfg.divisor   : shDiv;
  assign effMode    = atBoundary ? cfg.ratioMode : shMode;
  assign divLast    = (rawDiv == '0) ? '0 : rawDiv - DIV_W'(1);
  assign phaseLast  = effMode ? LAST_WIDE : LAST_NARROW;
  assign baseHit    = srcTick && (divCnt == divLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shDiv  <= DIV_W'(1);
      shMode <= 1'b0;
    end else if (atBoundary) begin
      shDiv  <= cfg.divisor;
      shMode <= cfg.ratioMode;
    end
  end

  // Divider and period phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= '0;
    end else if (srcTick) begin
      if (baseHit) begin
        divCnt <= '0;
        phase  <= (phase == phaseLast) ? '0 : phase + PH_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  // Per-output phase decode
  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
    assign phaseHit[gi] = ((int'(phase) % int'(ratioOf(gi, effMode))) == 0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateEn <= '0;
    end else begin
      rateEn <= baseHit ? (phaseHit & cfg.gate) : '0;
    end
  end

endmodule

// File: rtl/cpu_ratio_gen.sv
module cpu_ratio_gen
  import cpuratio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             armTick,
  input  logic             ddrTick,
  input  logic             ioTick,
  output logic [N_OUT-1:0] rateEn
);

  cfgBus_t cfgBus;

  cpuratio_regs uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .regSel (regSel),
    .wrData (regWrData),
    .rdData (regRdData),
    .cfg    (cfgBus)
  );

  cpuratio_core uCore (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfgBus),
    .armTick (armTick),
    .ddrTick (ddrTick),
    .ioTick  (ioTick),
    .rateEn  (rateEn)
  );

endmodule

// File: rtl/cpu_ratio_gen_chk.sv
module cpu_ratio_gen_chk
  import cpuratio_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             armTick,
  input logic             ddrTick,
  input logic             ioTick,
  input logic [N_OUT-1:0] rateEn,
  input cfgBus_t          cfg
);

  logic selTick;
  always_comb begin
    case (cfg.srcSel)
      SEL_DDR: selTick = ddrTick;
      SEL_IO:  selTick = ioTick;
      default: selTick = armTick;
    endcase
  end

  // R2 / R10: any strobe follows a tick of the selected stream
  a_r2_source_tick: assert property (@(posedge clk) disable iff (!rstN)
    (|rateEn) |-> $past(selTick));

  // R7: a gated-off output never pulses
  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_gate
    a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
      rateEn[gi] |-> $past(cfg.gate[gi]));
  end

  // R4: the slowest strobe marks a period start where all enabled fire
  a_r4_align_fast: assert property (@(posedge clk) disable iff (!rstN)
    (rateEn[3] && $past(cfg.gate[0])) |-> rateEn[0]);
  a_r4_align_half: assert property (@(posedge clk) disable iff (!rstN)
    (rateEn[3] && $past(cfg.gate[1])) |-> rateEn[1]);
  a_r4_align_third: assert property (@(posedge clk) disable iff (!rstN)
    (rateEn[3] && $past(cfg.gate[2])) |-> rateEn[2]);

endmodule

bind cpu_ratio_gen cpu_ratio_gen_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .armTick (armTick),
  .ddrTick (ddrTick),
  .ioTick  (ioTick),
  .rateEn  (rateEn),
  .cfg     (cfgBus)
);

// File: tb/cpu_ratio_gen_test.sv
`timescale 1ns/1ps
module cpu_ratio_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        armTick = 1'b0;
  logic        ddrTick = 1'b0;
  logic        ioTick = 1'b0;
  logic [3:0]  rateEn;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] ARM = 3'b001;
  localparam logic [2:0] DDR = 3'b010;
  localparam logic [2:0] IO  = 3'b100;
  localparam logic [2:0] NONE = 3'b000;

  always #2 clk = ~clk;

  cpu_ratio_gen uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .armTick(armTick), .ddrTick(ddrTick), .ioTick(ioTick), .rateEn(rateEn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected strobes at phase p of a common period
  function automatic logic [3:0] expVec(int p, bit mode, logic [3:0] gate);
    logic [3:0] v;
    v[0] = 1'b1;
    v[1] = (p % 2 == 0);
    v[2] = mode ? (p % 3 == 0) : (p % 2 == 0);
    v[3] = (p == 0);
    return v & gate;
  endfunction

  function automatic logic [31:0] ctrlWord(logic [1:0] src, logic [5:0] dv, logic [3:0] gate);
    return (32'(gate) << 24) | (32'(dv) << 8) | (32'(src) << 4);
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    {ioTick, ddrTick, armTick} = NONE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic sel, input logic [31:0] data);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] data);
    regSel = sel;
    #1 data = regRdData;
    regSel = 1'b0;
  endtask

  task automatic step(input logic [2:0] src, output logic [3:0] obs);
    {ioTick, ddrTick, armTick} = src;
    @(negedge clk);
    obs = rateEn;
    {ioTick, ddrTick, armTick} = NONE;
  endtask

  task automatic testReset();
    logic [31:0] d;
    doReset();
    readReg(1'b0, d);
    check(d == 32'h0000_0100, "R1", "control after reset", d, 32'h0000_0100);
    readReg(1'b1, d);
    check(d == 32'h0, "R1", "mode after reset", d, 32'h0);
    check(rateEn == 4'h0, "R1", "strobes after reset", 32'(rateEn), 32'h0);
  endtask

  task automatic testReadback();
    logic [31:0] d;
    doReset();
    writeReg(1'b0, 32'hFFFF_FFFF);
    readReg(1'b0, d);
    check(d == 32'h0F00_3F30, "R3", "control field readback", d, 32'h0F00_3F30);
    writeReg(1'b1, 32'hFFFF_FFFF);
    readReg(1'b1, d);
    check(d == 32'h1, "R3", "mode readback", d, 32'h1);
  endtask

  task automatic testNarrow();
    logic [3:0] o;
    doReset();
    writeReg(1'b0, ctrlWord(2'b00, 6'd1, 4'hF));
    for (int k = 0; k < 8; k++) begin
      step(ARM, o);
      check(o == expVec(k % 4, 1'b0, 4'hF), "R5", "mode0 div1 pattern (R4)", 32'(o),
            32'(expVec(k % 4, 1'b0, 4'hF)));
    end
  endtask

  task automatic testWide();
    logic [3:0] o;
    doReset();
    writeReg(1'b1, 32'h1);
    writeReg(1'b0, ctrlWord(2'b00, 6'd1, 4'hF));
    for (int k = 0; k < 12; k++) begin
      step(ARM, o);
      check(o == expVec(k % 6, 1'b1, 4'hF), "R6", "mode1 div1 pattern (R4)", 32'(o),
            32'(expVec(k % 6, 1'b1, 4'hF)));
    end
  endtask

  task automatic testDivide();
    logic [3:0] o;
    logic [3:0] e;
    doReset();
    writeReg(1'b0, ctrlWord(2'b00, 6'd3, 4'hF));
    for (int j = 0; j < 15; j++) begin
      step(ARM, o);
      e = (j % 3 == 2) ? expVec((j / 3) % 4, 1'b0, 4'hF) : 4'h0;
      check(o == e, "R3", "divide by 3 spacing", 32'(o), 32'(e));
    end
  endtask

  task automatic testZeroDiv();
    logic [3:0] o;
    logic [31:0] d;
    doReset();
    writeReg(1'b0, ctrlWord(2'b00, 6'd0, 4'hF));
    readReg(1'b0, d);
    check(d == ctrlWord(2'b00, 6'd0, 4'hF), "R9", "zero divisor readback", d,
          ctrlWord(2'b00, 6'd0, 4'hF));
    step(ARM, o);
    check(o == 4'hF, "R9", "zero divisor first tick", 32'(o), 32'hF);
    step(NONE, o);
    check(o == 4'h0, "R10", "single-cycle strobe", 32'(o), 32'h0);
    step(ARM, o);
    check(o == 4'h1, "R9", "zero divisor second tick", 32'(o), 32'h1);
  endtask

  task automatic testSource();
    logic [3:0] o;
    doReset();
    writeReg(1'b0, ctrlWord(2'b10, 6'd1, 4'hF));
    step(ARM, o);
    check(o == 4'h0, "R2", "arm ignored with code 10", 32'(o), 32'h0);
    step(IO, o);
    check(o == 4'h0, "R2", "io ignored with code 10", 32'(o), 32'h0);
    step(DDR, o);
    check(o == 4'hF, "R2", "ddr used with code 10", 32'(o), 32'hF);
    writeReg(1'b0, ctrlWord(2'b11, 6'd1, 4'hF));
    step(DDR, o);
    check(o == 4'h0, "R2", "ddr ignored with code 11", 32'(o), 32'h0);
    step(IO, o);
    check(o == 4'h1, "R2", "io used with code 11", 32'(o), 32'h1);
    writeReg(1'b0, ctrlWord(2'b01, 6'd1, 4'hF));
    step(ARM, o);
    check(o == 4'h7, "R2", "arm used with code 01", 32'(o), 32'h7);
  endtask

  task automatic testGates();
    logic [3:0] o;
    int pulses;
    for (int g = 0; g < 4; g++) begin
      doReset();
      writeReg(1'b1, 32'h1);
      writeReg(1'b0, ctrlWord(2'b00, 6'd1, 4'(1 << g)));
      pulses = 0;
      for (int k = 0; k < 12; k++) begin
        step(ARM, o);
        if (o != 4'h0) pulses++;
        check(o == expVec(k % 6, 1'b1, 4'(1 << g)), "R7", "single gate pattern", 32'(o),
              32'(expVec(k % 6, 1'b1, 4'(1 << g))));
      end
      check(pulses == 12 / int'(cpuratio_pkg::ratioOf(g, 1'b1)), "R7", "gated pulse count",
            32'(pulses), 32'(12 / int'(cpuratio_pkg::ratioOf(g, 1'b1))));
    end
  endtask

  task automatic testBoundary();
    logic [3:0] o;
    logic [3:0] e;
    // Mode change inside a period
    doReset();
    writeReg(1'b0, ctrlWord(2'b00, 6'd1, 4'hF));
    step(ARM, o);
    check(o == 4'hF, "R8", "period start before mode change", 32'(o), 32'hF);
    writeReg(1'b1, 32'h1);
    for (int k = 1; k < 10; k++) begin
      step(ARM, o);
      e = (k < 4) ? expVec(k, 1'b0, 4'hF) : expVec(k - 4, 1'b1, 4'hF);
      check(o == e, "R8", "mode change deferred", 32'(o), 32'(e));
    end
    // Divisor change inside a period
    doReset();
    writeReg(1'b0, ctrlWord(2'b00, 6'd1, 4'hF));
    step(ARM, o);
    writeReg(1'b0, ctrlWord(2'b00, 6'd2, 4'hF));
    for (int k = 1; k < 4; k++) begin
      step(ARM, o);
      check(o == expVec(k, 1'b0, 4'hF), "R8", "old divisor to period end", 32'(o),
            32'(expVec(k, 1'b0, 4'hF)));
    end
    for (int j = 0; j < 4; j++) begin
      step(ARM, o);
      e = (j % 2 == 1) ? expVec(j / 2, 1'b0, 4'hF) : 4'h0;
      check(o == e, "R8", "new divisor from period start", 32'(o), 32'(e));
    end
  endtask

  initial begin
    testReset();
    testReadback();
    testNarrow();
    testWide();
    testDivide();
    testZeroDiv();
    testSource();
    testGates();
    testBoundary();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule